// File: doc/BRIEF.md
# Debug Exception Target Selection and Generation Gate

This block decides, once per clock, which privilege level (0 to 3) takes debug exceptions and whether such exceptions may be raised at all from the current level and security state. It looks at the current level, the secure flag, the per-level 64-bit mode flags, whether level 3 exists, the hypervisor enable and its two trap controls, the monitor and kernel debug control words, and the debug mask flag.

From these it produces five registered outputs. The first is the routed target level. The second is a flag that permits exception generation. The third is a syndrome bit that marks exceptions taken to the same level. The fourth is the level that a software breakpoint instruction is taken to. The fifth is a flag that shows single-step is active. A core's exception logic samples these outputs and does not need to evaluate the routing rules itself.

Top module: `dbg_route_gate`

## Requirements
- R1: When `hyp_en` is 1 and either `trap_gen` or `trap_dbg` is 1, `tgt_lvl` is 2.
- R2: When R1 does not apply, `tgt_lvl` is 3 if `has_lvl3` is 1, `lvl_is64[3]` is 0 and `secure` is 1. In every other case `tgt_lvl` is 1.
- R3: `gen_en` is 0 whenever `cur_lvl` is 3.
- R4: When `secure` is 1 and `cur_lvl` is below 3, `gen_en` is 0 if bit 16 of `mon_ctl` is set.
- R5: When no rule above forces `gen_en` low and `cur_lvl` equals the target, `gen_en` is 1 exactly when bit 13 of `kern_ctl` is 1 and `dbg_mask` is 0.
- R6: When no rule above forces `gen_en` low and `cur_lvl` differs from the target, `gen_en` is 1 exactly when the target is above `cur_lvl`.
- R7: `same_lvl_syn` is 1 exactly when the target equals `cur_lvl`.
- R8: `bkpt_lvl` is the larger of the target and `cur_lvl`.
- R9: `sstep_act` is 1 exactly when bit 0 of `kern_ctl` is 1, `lvl_is64` at the target's index is 1, and `gen_en` would be 1.
- R10: All outputs show the inputs sampled at the previous rising edge of `clk`. While `rst` is high, the outputs reset on the clock edge to `tgt_lvl`=1, `gen_en`=0, `same_lvl_syn`=0, `bkpt_lvl`=1 and `sstep_act`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_lvl | input | 2 | Current privilege level |
| secure | input | 1 | Core is in secure state |
| lvl_is64 | input | 4 | Bit n is 1 when level n runs in 64-bit mode |
| has_lvl3 | input | 1 | Level 3 is implemented |
| hyp_en | input | 1 | Hypervisor level is enabled |
| trap_gen | input | 1 | Hypervisor traps general exceptions |
| trap_dbg | input | 1 | Hypervisor traps debug exceptions |
| mon_ctl | input | CTL_W | Monitor debug control word |
| kern_ctl | input | CTL_W | Kernel debug control word |
| dbg_mask | input | 1 | Debug exception mask |
| tgt_lvl | output | 2 | Routed debug target level |
| gen_en | output | 1 | Debug exceptions may be generated |
| same_lvl_syn | output | 1 | Syndrome bit for same-level exceptions |
| bkpt_lvl | output | 2 | Level taken by breakpoint instructions |
| sstep_act | output | 1 | Single-step is active |

## Verification
The assertions assume that every input holds a known value at each rising edge. They compare the outputs against inputs sampled one edge earlier, so they also assume that reset has been released for at least one edge. The bench meets both assumptions. It holds reset for several cycles and applies every input change on the falling edge. It drives each control word with only the bit under test set or cleared, plus a changing pattern in the other bits, so unrelated bits never read as zero by accident.

// File: rtl/dbg_route_gate.sv
module dbg_route_gate #(
  parameter int CTL_W   = 32,
  parameter int SDD_BIT = 16,
  parameter int KDE_BIT = 13,
  parameter int SS_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cur_lvl,
  input  logic             secure,
  input  logic [3:0]       lvl_is64,
  input  logic             has_lvl3,
  input  logic             hyp_en,
  input  logic             trap_gen,
  input  logic             trap_dbg,
  input  logic [CTL_W-1:0] mon_ctl,
  input  logic [CTL_W-1:0] kern_ctl,
  input  logic             dbg_mask,
  output logic [1:0]       tgt_lvl,
  output logic             gen_en,
  output logic             same_lvl_syn,
  output logic [1:0]       bkpt_lvl,
  output logic             sstep_act
);

  logic       to_hyp, to_mon;
  logic [1:0] tgt_c;
  logic       same_c, gen_c;

  assign to_hyp = hyp_en & (trap_gen | trap_dbg);
  assign to_mon = has_lvl3 & ~lvl_is64[3] & secure;
  assign tgt_c  = to_hyp ? 2'd2 : (to_mon ? 2'd3 : 2'd1);
  assign same_c = (tgt_c == cur_lvl);

  always_comb begin
    if (cur_lvl == 2'd3)
      gen_c = 1'b0;
    else if (secure && mon_ctl[SDD_BIT])
      gen_c = 1'b0;
    else if (same_c)
      gen_c = kern_ctl[KDE_BIT] & ~dbg_mask;
    else
      gen_c = (tgt_c > cur_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lvl      <= 2'd1;
      gen_en       <= 1'b0;
      same_lvl_syn <= 1'b0;
      bkpt_lvl     <= 2'd1;
      sstep_act    <= 1'b0;
    end else begin
      tgt_lvl      <= tgt_c;
      gen_en       <= gen_c;
      same_lvl_syn <= same_c;
      bkpt_lvl     <= (tgt_c < cur_lvl) ? cur_lvl : tgt_c;
      sstep_act    <= kern_ctl[SS_BIT] & lvl_is64[tgt_c] & gen_c;
    end
  end

endmodule

module dbg_route_gate_chk #(
  parameter int CTL_W   = 32,
  parameter int SDD_BIT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cur_lvl,
  input logic             secure,
  input logic             hyp_en,
  input logic             trap_gen,
  input logic             trap_dbg,
  input logic [CTL_W-1:0] mon_ctl,
  input logic [1:0]       tgt_lvl,
  input logic             gen_en,
  input logic             same_lvl_syn,
  input logic [1:0]       bkpt_lvl,
  input logic             sstep_act
);

  assert_hyp_route_R1: assert property (@(posedge clk) disable iff (rst)
    (hyp_en && (trap_gen || trap_dbg)) |=> tgt_lvl == 2'd2);

  assert_lvl3_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_lvl == 2'd3) |=> !gen_en);

  assert_sdd_block_R4: assert property (@(posedge clk) disable iff (rst)
    (secure && mon_ctl[SDD_BIT]) |=> !gen_en);

  assert_syn_same_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> same_lvl_syn == (tgt_lvl == $past(cur_lvl)));

  assert_bkpt_floor_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bkpt_lvl >= $past(cur_lvl)) && (bkpt_lvl >= tgt_lvl));

  assert_sstep_gen_R9: assert property (@(posedge clk) disable iff (rst)
    sstep_act |-> gen_en);

  assert_reset_vals_R10: assert property (@(posedge clk)
    rst |=> (tgt_lvl == 2'd1) && !gen_en && !sstep_act);

endmodule

bind dbg_route_gate dbg_route_gate_chk #(.CTL_W(CTL_W), .SDD_BIT(SDD_BIT)) u_chk (
  .clk(clk), .rst(rst), .cur_lvl(cur_lvl), .secure(secure), .hyp_en(hyp_en),
  .trap_gen(trap_gen), .trap_dbg(trap_dbg), .mon_ctl(mon_ctl),
  .tgt_lvl(tgt_lvl), .gen_en(gen_en), .same_lvl_syn(same_lvl_syn),
  .bkpt_lvl(bkpt_lvl), .sstep_act(sstep_act)
);

// File: tb/dbg_route_gate_tb.sv
module dbg_route_gate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cur_lvl = '0;
  logic        secure = 1'b0;
  logic [3:0]  lvl_is64 = '0;
  logic        has_lvl3 = 1'b0;
  logic        hyp_en = 1'b0;
  logic        trap_gen = 1'b0;
  logic        trap_dbg = 1'b0;
  logic [31:0] mon_ctl = '0;
  logic [31:0] kern_ctl = '0;
  logic        dbg_mask = 1'b0;
  logic [1:0]  tgt_lvl, bkpt_lvl;
  logic        gen_en, same_lvl_syn, sstep_act;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dbg_route_gate u_dut (
    .clk(clk), .rst(rst), .cur_lvl(cur_lvl), .secure(secure),
    .lvl_is64(lvl_is64), .has_lvl3(has_lvl3), .hyp_en(hyp_en),
    .trap_gen(trap_gen), .trap_dbg(trap_dbg), .mon_ctl(mon_ctl),
    .kern_ctl(kern_ctl), .dbg_mask(dbg_mask), .tgt_lvl(tgt_lvl),
    .gen_en(gen_en), .same_lvl_syn(same_lvl_syn), .bkpt_lvl(bkpt_lvl),
    .sstep_act(sstep_act)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cur=%0d sec=%0b is64=%b l3=%0b hyp=%0b tg=%0b td=%0b)",
               tag, act, exp, cur_lvl, secure, lvl_is64, has_lvl3, hyp_en, trap_gen, trap_dbg);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    check("R10 tgt reset", tgt_lvl, 1);
    check("R10 gen reset", gen_en, 0);
    check("R10 syn reset", same_lvl_syn, 0);
    check("R10 bkpt reset", bkpt_lvl, 1);
    check("R10 ss reset", sstep_act, 0);
    rst = 1'b0;
    for (int v = 0; v < 8192; v++) begin
      int e_tgt, e_gen, e_same, e_bkpt, e_ss;
      logic lo64;
      cur_lvl  = v[1:0];
      secure   = v[2];
      has_lvl3 = v[3];
      lo64     = v[4];
      lvl_is64 = {v[5], lo64, ~lo64, lo64};
      hyp_en   = v[6];
      trap_gen = v[7];
      trap_dbg = v[8];
      mon_ctl  = (32'h5A5A_A5A5 ^ (32'(v) << 20)) & ~(32'h1 << 16) | (32'(v[9]) << 16);
      kern_ctl = (32'hC3C3_3C3C ^ 32'(v) << 18) & ~32'h2001 | (32'(v[10]) << 13) | 32'(v[12]);
      dbg_mask = v[11];

      if (hyp_en && (trap_gen || trap_dbg)) e_tgt = 2;
      else if (has_lvl3 && !lvl_is64[3] && secure) e_tgt = 3;
      else e_tgt = 1;
      e_same = (e_tgt == cur_lvl) ? 1 : 0;
      if (cur_lvl == 3) e_gen = 0;
      else if (secure && v[9]) e_gen = 0;
      else if (e_same == 1) e_gen = (v[10] && !dbg_mask) ? 1 : 0;
      else e_gen = (e_tgt > cur_lvl) ? 1 : 0;
      e_bkpt = (e_tgt < cur_lvl) ? cur_lvl : e_tgt;
      e_ss = (v[12] && lvl_is64[e_tgt] && e_gen == 1) ? 1 : 0;

      @(negedge clk);
      check("R1 R2 target", tgt_lvl, e_tgt);
      check("R3 R4 R5 R6 generate", gen_en, e_gen);
      check("R7 syndrome", same_lvl_syn, e_same);
      check("R8 breakpoint level", bkpt_lvl, e_bkpt);
      check("R9 single-step", sstep_act, e_ss);
    end
    // R10: one-cycle latency, then reset returns the reset values
    cur_lvl = 2'd0; secure = 1'b0; hyp_en = 1'b1; trap_dbg = 1'b1;
    kern_ctl = 32'h1; mon_ctl = '0; lvl_is64 = 4'hF;
    @(posedge clk); #1;
    check("R10 latency tgt", tgt_lvl, 2);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset tgt", tgt_lvl, 2);
    @(negedge clk);
    check("R10 reset reapplied tgt", tgt_lvl, 1);
    check("R10 reset reapplied ss", sstep_act, 0);
    finish_run();
  end

endmodule